// File: doc/BRIEF.md
# Micro-operation register-transfer datapath

An 8-bit accumulator datapath that carries out exactly one numbered register transfer on each clock edge while a valid strobe is high. It holds six working registers: a program counter, a memory address register, a memory data register, an accumulator, an index register and a stack pointer. It also holds zero, negative and carry flags. A sequencer outside the block issues a 6-bit micro-operation code with the strobe. The block has no opcode decoding and no instruction sequencing of its own.

Memory is a single-port 256-byte array outside the block. The address always comes from the memory address register. Read data is taken into the data register on the clock edge of a read code. Write data is the data register, and it is written with a strobe during the cycle of a write code. All registers wrap modulo 256. Codes outside the legal set do nothing except raise a one-cycle error pulse.

Top module: `uop_datapath`

## Requirements
- R1: While rst_ni is low, every register output, every flag and illegal_o are zero.
- R2: Code 1 loads MAR from PC. Code 19 loads it from XR, code 29 from SP and code 23 from MDR. mem_addr_o always equals MAR.
- R3: Code 2 captures mem_rdata_i into MDR at the clock edge. Code 22 raises mem_we_o in its own cycle, with mem_wdata_o equal to MDR. mem_we_o is low for every other code and whenever uop_valid_i is low.
- R4: Code 4 increments PC, code 28 loads PC from MDR, and code 34 copies PC into XR.
- R5: Code 5 moves MDR to ACC, code 8 moves ACC to MDR, code 17 moves MDR to XR, code 18 moves XR to MDR, code 32 moves SP to MDR, and code 33 moves MDR to SP.
- R6: Codes 6/7 increment/decrement ACC, 20/21 XR, 26/27 MDR and 30/31 SP, all wrapping modulo 256.
- R7: Codes 9 to 13 write ACC+MDR, ACC−MDR, ACC^MDR, ACC&MDR and ACC|MDR into ACC. Code 14 writes ~ACC.
- R8: Code 15 shifts ACC left by one and code 16 shifts it right by one, filling with zero. Code 24 clears ACC and code 25 clears XR.
- R9: On codes 9 and 10, carry becomes the carry out of the addition or the borrow of the subtraction (1 when ACC < MDR). Zero is set when the 8-bit result is 0, and negative takes result bit 7.
- R10: Code 35 sets the flags from ACC−MDR and code 36 from XR−MDR, with the same rules as R9. No register changes.
- R11: The three flags keep their value on every code other than 9, 10, 35 and 36.
- R12: Codes 0, 3 and 37 to 63 are illegal. They change no register or flag and raise no write, and illegal_o is high for the one cycle after the edge that accepted them.
- R13: With uop_valid_i low, no register or flag changes, no write occurs, and illegal_o is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uop_valid_i | input | 1 | Micro-operation strobe |
| uop_code_i | input | 6 | Micro-operation code |
| mem_rdata_i | input | 8 | Memory read data for address mem_addr_o |
| mem_addr_o | output | 8 | Memory address (MAR) |
| mem_wdata_o | output | 8 | Memory write data (MDR) |
| mem_we_o | output | 1 | Memory write strobe |
| pc_o | output | 8 | Program counter |
| mar_o | output | 8 | Memory address register |
| mdr_o | output | 8 | Memory data register |
| acc_o | output | 8 | Accumulator |
| xr_o | output | 8 | Index register |
| sp_o | output | 8 | Stack pointer |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| carry_o | output | 1 | Carry / borrow flag |
| illegal_o | output | 1 | One-cycle illegal-code pulse |

## Verification
Register, flag and illegal-pulse results are due one clock after the code is presented. The bench drives each code on a falling edge and compares all outputs against its model on the next falling edge, after exactly one rising edge. The write strobe and write data are combinational, so they are checked 1 ns after the code is driven, before that rising edge. The bench memory model takes the write on that same edge, and a later read code returns the value through MDR.

// File: rtl/uop_pkg.sv
package uop_pkg;
  localparam int UOP_W = 6;
  typedef logic [UOP_W-1:0] uop_t;

  localparam uop_t UOP_MAR_PC   = 6'd1;
  localparam uop_t UOP_RD_MEM   = 6'd2;
  localparam uop_t UOP_PC_INC   = 6'd4;
  localparam uop_t UOP_ACC_MDR  = 6'd5;
  localparam uop_t UOP_ACC_INC  = 6'd6;
  localparam uop_t UOP_ACC_DEC  = 6'd7;
  localparam uop_t UOP_MDR_ACC  = 6'd8;
  localparam uop_t UOP_ADD      = 6'd9;
  localparam uop_t UOP_SUB      = 6'd10;
  localparam uop_t UOP_XOR      = 6'd11;
  localparam uop_t UOP_AND      = 6'd12;
  localparam uop_t UOP_OR       = 6'd13;
  localparam uop_t UOP_INV      = 6'd14;
  localparam uop_t UOP_SHL      = 6'd15;
  localparam uop_t UOP_SHR      = 6'd16;
  localparam uop_t UOP_XR_MDR   = 6'd17;
  localparam uop_t UOP_MDR_XR   = 6'd18;
  localparam uop_t UOP_MAR_XR   = 6'd19;
  localparam uop_t UOP_XR_INC   = 6'd20;
  localparam uop_t UOP_XR_DEC   = 6'd21;
  localparam uop_t UOP_WR_MEM   = 6'd22;
  localparam uop_t UOP_MAR_MDR  = 6'd23;
  localparam uop_t UOP_ACC_CLR  = 6'd24;
  localparam uop_t UOP_XR_CLR   = 6'd25;
  localparam uop_t UOP_MDR_INC  = 6'd26;
  localparam uop_t UOP_MDR_DEC  = 6'd27;
  localparam uop_t UOP_PC_MDR   = 6'd28;
  localparam uop_t UOP_MAR_SP   = 6'd29;
  localparam uop_t UOP_SP_INC   = 6'd30;
  localparam uop_t UOP_SP_DEC   = 6'd31;
  localparam uop_t UOP_MDR_SP   = 6'd32;
  localparam uop_t UOP_SP_MDR   = 6'd33;
  localparam uop_t UOP_XR_PC    = 6'd34;
  localparam uop_t UOP_CMP_ACC  = 6'd35;
  localparam uop_t UOP_CMP_XR   = 6'd36;

  typedef enum logic [2:0] {MAR_HOLD, MAR_PC, MAR_XR, MAR_SP, MAR_MDR} mar_sel_e;
  typedef enum logic [2:0] {MDR_HOLD, MDR_MEM, MDR_ACC, MDR_XR, MDR_SP, MDR_INC, MDR_DEC} mdr_sel_e;
  typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_MDR} pc_sel_e;
  typedef enum logic [1:0] {ACC_HOLD, ACC_MDR, ACC_ALU, ACC_CLR} acc_sel_e;
  typedef enum logic [2:0] {XR_HOLD, XR_MDR, XR_INC, XR_DEC, XR_CLR, XR_PC} xr_sel_e;
  typedef enum logic [1:0] {SP_HOLD, SP_INC, SP_DEC, SP_MDR} sp_sel_e;
  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_XOR, ALU_AND, ALU_OR, ALU_INV,
    ALU_SHL, ALU_SHR, ALU_INC, ALU_DEC
  } alu_op_e;

  typedef struct packed {
    mar_sel_e mar;
    mdr_sel_e mdr;
    pc_sel_e  pc;
    acc_sel_e acc;
    xr_sel_e  xr;
    sp_sel_e  sp;
    alu_op_e  alu_op;
    logic     alu_a_xr;
    logic     flag_en;
    logic     mem_we;
    logic     illegal;
  } uop_ctrl_t;
endpackage

// File: rtl/uop_decode.sv
module uop_decode
  import uop_pkg::*;
(
  input  logic      valid_i,
  input  uop_t      code_i,
  output uop_ctrl_t ctrl_o
);
  always_comb begin
    ctrl_o = '{mar: MAR_HOLD, mdr: MDR_HOLD, pc: PC_HOLD, acc: ACC_HOLD,
               xr: XR_HOLD, sp: SP_HOLD, alu_op: ALU_ADD, alu_a_xr: 1'b0,
               flag_en: 1'b0, mem_we: 1'b0, illegal: 1'b0};
    if (valid_i) begin
      case (code_i)
        UOP_MAR_PC:  ctrl_o.mar = MAR_PC;
        UOP_MAR_XR:  ctrl_o.mar = MAR_XR;
        UOP_MAR_SP:  ctrl_o.mar = MAR_SP;
        UOP_MAR_MDR: ctrl_o.mar = MAR_MDR;
        UOP_RD_MEM:  ctrl_o.mdr = MDR_MEM;
        UOP_WR_MEM:  ctrl_o.mem_we = 1'b1;
        UOP_PC_INC:  ctrl_o.pc = PC_INC;
        UOP_PC_MDR:  ctrl_o.pc = PC_MDR;
        UOP_XR_PC:   ctrl_o.xr = XR_PC;
        UOP_ACC_MDR: ctrl_o.acc = ACC_MDR;
        UOP_MDR_ACC: ctrl_o.mdr = MDR_ACC;
        UOP_XR_MDR:  ctrl_o.xr = XR_MDR;
        UOP_MDR_XR:  ctrl_o.mdr = MDR_XR;
        UOP_MDR_SP:  ctrl_o.mdr = MDR_SP;
        UOP_SP_MDR:  ctrl_o.sp = SP_MDR;
        UOP_XR_INC:  ctrl_o.xr = XR_INC;
        UOP_XR_DEC:  ctrl_o.xr = XR_DEC;
        UOP_MDR_INC: ctrl_o.mdr = MDR_INC;
        UOP_MDR_DEC: ctrl_o.mdr = MDR_DEC;
        UOP_SP_INC:  ctrl_o.sp = SP_INC;
        UOP_SP_DEC:  ctrl_o.sp = SP_DEC;
        UOP_ACC_CLR: ctrl_o.acc = ACC_CLR;
        UOP_XR_CLR:  ctrl_o.xr = XR_CLR;
        UOP_ACC_INC: begin ctrl_o.acc = ACC_ALU; ctrl_o.alu_op = ALU_INC; end
        UOP_ACC_DEC: begin ctrl_o.acc = ACC_ALU; ctrl_o.alu_op = ALU_DEC; end
        UOP_XOR:     begin ctrl_o.acc = ACC_ALU; ctrl_o.alu_op = ALU_XOR; end
        UOP_AND:     begin ctrl_o.acc = ACC_ALU; ctrl_o.alu_op = ALU_AND; end
        UOP_OR:      begin ctrl_o.acc = ACC_ALU; ctrl_o.alu_op = ALU_OR;  end
        UOP_INV:     begin ctrl_o.acc = ACC_ALU; ctrl_o.alu_op = ALU_INV; end
        UOP_SHL:     begin ctrl_o.acc = ACC_ALU; ctrl_o.alu_op = ALU_SHL; end
        UOP_SHR:     begin ctrl_o.acc = ACC_ALU; ctrl_o.alu_op = ALU_SHR; end
        UOP_ADD: begin
          ctrl_o.acc = ACC_ALU; ctrl_o.alu_op = ALU_ADD; ctrl_o.flag_en = 1'b1;
        end
        UOP_SUB: begin
          ctrl_o.acc = ACC_ALU; ctrl_o.alu_op = ALU_SUB; ctrl_o.flag_en = 1'b1;
        end
        UOP_CMP_ACC: begin
          ctrl_o.alu_op = ALU_SUB; ctrl_o.flag_en = 1'b1;
        end
        UOP_CMP_XR: begin
          ctrl_o.alu_op = ALU_SUB; ctrl_o.alu_a_xr = 1'b1; ctrl_o.flag_en = 1'b1;
        end
        default: ctrl_o.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/uop_alu.sv
module uop_alu
  import uop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W:0] wide;

  always_comb begin
    wide = '0;
    case (op_i)
      ALU_ADD: wide = {1'b0, a_i} + {1'b0, b_i};
      ALU_SUB: wide = {1'b0, a_i} - {1'b0, b_i}; // msb = borrow
      ALU_XOR: wide = {1'b0, a_i ^ b_i};
      ALU_AND: wide = {1'b0, a_i & b_i};
      ALU_OR:  wide = {1'b0, a_i | b_i};
      ALU_INV: wide = {1'b0, ~a_i};
      ALU_SHL: wide = {1'b0, a_i[DATA_W-2:0], 1'b0};
      ALU_SHR: wide = {2'b00, a_i[DATA_W-1:1]};
      ALU_INC: wide = {1'b0, a_i + ONE};
      ALU_DEC: wide = {1'b0, a_i - ONE};
      default: wide = '0;
    endcase
  end

  assign res_o   = wide[DATA_W-1:0];
  assign carry_o = wide[DATA_W];
endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uop_valid_i,
  input  logic [UOP_W-1:0]  uop_code_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] xr_o,
  output logic [DATA_W-1:0] sp_o,
  output logic              zero_o,
  output logic              neg_o,
  output logic              carry_o,
  output logic              illegal_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  uop_ctrl_t         ctrl;
  logic [DATA_W-1:0] pc_q, mar_q, mdr_q, acc_q, xr_q, sp_q;
  logic              zero_q, neg_q, carry_q, illegal_q;
  logic [DATA_W-1:0] alu_a, alu_res;
  logic              alu_carry;

  uop_decode i_decode (
    .valid_i (uop_valid_i),
    .code_i  (uop_code_i),
    .ctrl_o  (ctrl)
  );

  assign alu_a = ctrl.alu_a_xr ? xr_q : acc_q;

  uop_alu #(.DATA_W(DATA_W)) i_alu (
    .a_i     (alu_a),
    .b_i     (mdr_q),
    .op_i    (ctrl.alu_op),
    .res_o   (alu_res),
    .carry_o (alu_carry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mar_q <= '0;
    else begin
      case (ctrl.mar)
        MAR_PC:  mar_q <= pc_q;
        MAR_XR:  mar_q <= xr_q;
        MAR_SP:  mar_q <= sp_q;
        MAR_MDR: mar_q <= mdr_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mdr_q <= '0;
    else begin
      case (ctrl.mdr)
        MDR_MEM: mdr_q <= mem_rdata_i;
        MDR_ACC: mdr_q <= acc_q;
        MDR_XR:  mdr_q <= xr_q;
        MDR_SP:  mdr_q <= sp_q;
        MDR_INC: mdr_q <= mdr_q + ONE;
        MDR_DEC: mdr_q <= mdr_q - ONE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else begin
      case (ctrl.pc)
        PC_INC:  pc_q <= pc_q + ONE;
        PC_MDR:  pc_q <= mdr_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else begin
      case (ctrl.acc)
        ACC_MDR: acc_q <= mdr_q;
        ACC_ALU: acc_q <= alu_res;
        ACC_CLR: acc_q <= '0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) xr_q <= '0;
    else begin
      case (ctrl.xr)
        XR_MDR:  xr_q <= mdr_q;
        XR_INC:  xr_q <= xr_q + ONE;
        XR_DEC:  xr_q <= xr_q - ONE;
        XR_CLR:  xr_q <= '0;
        XR_PC:   xr_q <= pc_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= '0;
    else begin
      case (ctrl.sp)
        SP_INC:  sp_q <= sp_q + ONE;
        SP_DEC:  sp_q <= sp_q - ONE;
        SP_MDR:  sp_q <= mdr_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_q    <= 1'b0;
      neg_q     <= 1'b0;
      carry_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= ctrl.illegal;
      if (ctrl.flag_en) begin
        zero_q  <= (alu_res == '0);
        neg_q   <= alu_res[DATA_W-1];
        carry_q <= alu_carry;
      end
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mdr_q;
  assign mem_we_o    = ctrl.mem_we;
  assign pc_o        = pc_q;
  assign mar_o       = mar_q;
  assign mdr_o       = mdr_q;
  assign acc_o       = acc_q;
  assign xr_o        = xr_q;
  assign sp_o        = sp_q;
  assign zero_o      = zero_q;
  assign neg_o       = neg_q;
  assign carry_o     = carry_q;
  assign illegal_o   = illegal_q;

  logic is_flag_code;
  assign is_flag_code = uop_valid_i &&
    (uop_code_i == UOP_ADD || uop_code_i == UOP_SUB ||
     uop_code_i == UOP_CMP_ACC || uop_code_i == UOP_CMP_XR);

  assert_write_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (uop_valid_i && uop_code_i == UOP_WR_MEM));

  assert_cmp_no_reg_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_i && (uop_code_i == UOP_CMP_ACC || uop_code_i == UOP_CMP_XR))
    |=> ($stable(acc_q) && $stable(xr_q) && $stable(mdr_q)));

  assert_flags_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_flag_code |=> $stable({zero_q, neg_q, carry_q}));

  assert_illegal_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.illegal |=> (illegal_o && $stable(acc_q) && $stable(pc_q) && $stable(sp_q)));

  assert_illegal_no_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.illegal |-> !mem_we_o);

  assert_idle_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uop_valid_i |=> ($stable(acc_q) && $stable(xr_q) && $stable(pc_q) &&
                      $stable(sp_q) && $stable(mar_q) && $stable(mdr_q) && !illegal_o));
endmodule

// File: tb/test_uop_datapath.sv
module test_uop_datapath;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uop_valid = 1'b0;
  logic [5:0] uop_code = '0;
  logic [7:0] mem_rdata, mem_addr, mem_wdata;
  logic       mem_we;
  logic [7:0] pc, mar, mdr, acc, xr, sp;
  logic       zero, neg, carry, illegal;

  logic [7:0] mem [256];
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // expected state
  logic [7:0] e_pc, e_mar, e_mdr, e_acc, e_xr, e_sp;
  logic       e_z, e_n, e_c, e_ill;

  always #(CLK_P/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  uop_datapath i_uop_datapath (
    .clk_i(clk), .rst_ni(rst_n), .uop_valid_i(uop_valid), .uop_code_i(uop_code),
    .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .pc_o(pc), .mar_o(mar), .mdr_o(mdr), .acc_o(acc),
    .xr_o(xr), .sp_o(sp), .zero_o(zero), .neg_o(neg), .carry_o(carry),
    .illegal_o(illegal)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic is_illegal(input logic [5:0] c);
    return (c == 6'd0) || (c == 6'd3) || (c > 6'd36);
  endfunction

  function automatic string req_of(input logic v, input logic [5:0] c);
    if (!v) return "R13";
    if (is_illegal(c)) return "R12";
    case (c)
      6'd1, 6'd19, 6'd23, 6'd29: return "R2";
      6'd2, 6'd22: return "R3";
      6'd4, 6'd28, 6'd34: return "R4";
      6'd5, 6'd8, 6'd17, 6'd18, 6'd32, 6'd33: return "R5";
      6'd6, 6'd7, 6'd20, 6'd21, 6'd26, 6'd27, 6'd30, 6'd31: return "R6";
      6'd11, 6'd12, 6'd13, 6'd14: return "R7";
      6'd9, 6'd10: return "R9";
      6'd15, 6'd16, 6'd24, 6'd25: return "R8";
      6'd35, 6'd36: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic set_flags(input logic [7:0] a, input logic [7:0] b, input logic sub);
    logic [8:0] w;
    w = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    e_z = (w[7:0] == 8'h00);
    e_n = w[7];
    e_c = w[8];
  endtask

  task automatic compare_all(input string req);
    chk(req, "pc", pc, e_pc);
    chk(req, "mar", mar, e_mar);
    chk("R2", "mem_addr", mem_addr, e_mar);
    chk(req, "mdr", mdr, e_mdr);
    chk(req, "acc", acc, e_acc);
    chk(req, "xr", xr, e_xr);
    chk(req, "sp", sp, e_sp);
    chk(req, "zero", zero, e_z);
    chk(req, "neg", neg, e_n);
    chk(req, "carry", carry, e_c);
    chk(req, "illegal", illegal, e_ill);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic v, input logic [5:0] c);
    logic [7:0] rd;
    string req;
    rd = mem[e_mar];
    req = req_of(v, c);
    uop_valid = v;
    uop_code = c;
    #1;
    chk("R3", "mem_we", mem_we, v && c == 6'd22);
    if (v && c == 6'd22) chk("R3", "mem_wdata", mem_wdata, e_mdr);
    if (v) begin
      case (c)
        6'd1:  e_mar = e_pc;
        6'd19: e_mar = e_xr;
        6'd29: e_mar = e_sp;
        6'd23: e_mar = e_mdr;
        6'd2:  e_mdr = rd;
        6'd4:  e_pc = e_pc + 8'd1;
        6'd28: e_pc = e_mdr;
        6'd34: e_xr = e_pc;
        6'd5:  e_acc = e_mdr;
        6'd8:  e_mdr = e_acc;
        6'd17: e_xr = e_mdr;
        6'd18: e_mdr = e_xr;
        6'd32: e_mdr = e_sp;
        6'd33: e_sp = e_mdr;
        6'd6:  e_acc = e_acc + 8'd1;
        6'd7:  e_acc = e_acc - 8'd1;
        6'd20: e_xr = e_xr + 8'd1;
        6'd21: e_xr = e_xr - 8'd1;
        6'd26: e_mdr = e_mdr + 8'd1;
        6'd27: e_mdr = e_mdr - 8'd1;
        6'd30: e_sp = e_sp + 8'd1;
        6'd31: e_sp = e_sp - 8'd1;
        6'd9:  begin set_flags(e_acc, e_mdr, 1'b0); e_acc = e_acc + e_mdr; end
        6'd10: begin set_flags(e_acc, e_mdr, 1'b1); e_acc = e_acc - e_mdr; end
        6'd11: e_acc = e_acc ^ e_mdr;
        6'd12: e_acc = e_acc & e_mdr;
        6'd13: e_acc = e_acc | e_mdr;
        6'd14: e_acc = ~e_acc;
        6'd15: e_acc = e_acc << 1;
        6'd16: e_acc = e_acc >> 1;
        6'd24: e_acc = 8'h00;
        6'd25: e_xr = 8'h00;
        6'd35: set_flags(e_acc, e_mdr, 1'b1);
        6'd36: set_flags(e_xr, e_mdr, 1'b1);
        default: ;
      endcase
    end
    e_ill = v && is_illegal(c);
    @(negedge clk);
    compare_all(req);
  endtask

  // put a value into MDR via memory at current MAR
  task automatic load_mdr(input logic [7:0] val);
    mem[e_mar] = val;
    step(1'b1, 6'd2);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] mem_before;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    {e_pc, e_mar, e_mdr, e_acc, e_xr, e_sp} = '0;
    {e_z, e_n, e_c, e_ill} = '0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R9: 0xFF + 0x01 wraps to 0 with carry and zero
    load_mdr(8'hFF); step(1, 6'd5);
    load_mdr(8'h01); step(1, 6'd9);
    chk("R9", "add wrap carry", carry, 1);
    chk("R9", "add wrap zero", zero, 1);
    // R9: 0 - 1 gives 0xFF with borrow and negative
    step(1, 6'd10);
    chk("R9", "sub borrow", carry, 1);
    chk("R9", "sub neg", neg, 1);
    // R8: shifts of 0x81
    load_mdr(8'h81); step(1, 6'd5); step(1, 6'd15);
    chk("R8", "shl", acc, 8'h02);
    step(1, 6'd5); step(1, 6'd16);
    chk("R8", "shr", acc, 8'h40);
    // R10: compare equal, ACC kept
    load_mdr(8'h40); step(1, 6'd35);
    chk("R10", "cmp eq zero", zero, 1);
    chk("R10", "cmp acc kept", acc, 8'h40);
    step(1, 6'd17); load_mdr(8'h41); step(1, 6'd36);
    chk("R10", "cmpx borrow", carry, 1);
    // R6: SP wraps below zero
    step(1, 6'd33);
    load_mdr(8'h00); step(1, 6'd33); step(1, 6'd31);
    chk("R6", "sp wrap", sp, 8'hFF);
    // R3: write then read back through MDR
    step(1, 6'd29); load_mdr(8'h5A); step(1, 6'd26); step(1, 6'd22);
    step(1, 6'd24); step(1, 6'd8); step(1, 6'd2);
    chk("R3", "readback", mdr, 8'h5B);
    // R12: illegal codes keep memory intact
    mem_before = mem[e_mar];
    step(1, 6'd3); step(1, 6'd0); step(1, 6'd63);
    chk("R12", "mem intact", mem[e_mar], mem_before);
    step(0, 6'd22);
    chk("R13", "mem intact idle", mem[e_mar], mem_before);
    // sweep every code once
    for (int c = 0; c < 64; c++) step(1, 6'(c));
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic v;
      logic [5:0] c;
      v = ($urandom % 10) != 0;
      c = ($urandom % 8 == 0) ? 6'($urandom) : 6'(1 + $urandom % 36);
      step(v, c);
    end
    // R1: asynchronous reset clears everything mid-run
    #2 rst_n = 1'b0;
    {e_pc, e_mar, e_mdr, e_acc, e_xr, e_sp} = '0;
    {e_z, e_n, e_c, e_ill} = '0;
    uop_valid = 1'b0;
    #1 compare_all("R1");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule